// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block sits between an interrupt controller and a processor core and decides which request the core takes next. Three request kinds arrive: a reset request, a non-maskable interrupt (NMI) and a maskable request that carries a priority level. Reset requests and NMIs are latched as pending flags. The maskable level is held as a pending value that changes only when the controller writes a new one. The core reports its current mask level on every cycle. When a request wins arbitration, the block issues a one-cycle take pulse with the request kind, the handler address and the mask level the core loads into its status word. When a maskable level is taken, an acknowledge carrying that level is sent back to the controller in the same cycle.

Handler addresses for maskable levels are a fixed base plus a per-level 16-bit offset. The offsets live in a small register window on a simple request/read-data bus. The window also holds a read-only memory-control word and a read-only mode word.

The core side and the controller side are plain control pins with no back-pressure. The core must accept a take pulse in the cycle it appears. A bus read always returns data one cycle after the request, marked by `bus_rvalid_o`, and the bus never stalls.

Top module: `irq_accept_unit`

## Requirements
- R1: After hardware reset, no take is issued, the pending level is 7 (no maskable request), both pending flags are clear and every vector offset reads as zero.
- R2: A pending reset request wins over a pending NMI, and an NMI wins over a maskable level. One request is taken per decision.
- R3: A maskable level L is taken only when L is strictly less than `cur_mask_i`. Level 7 is never taken.
- R4: A taken NMI reports kind 2 and handler address NMI_PC (default 0x40000008). Its pending flag clears, so one NMI pulse gives exactly one take.
- R5: A taken level L reports kind 3, handler address VEC_BASE (default 0x40000000) plus the zero-extended offset register of L, and `new_mask_o` equal to L. For reset and NMI takes, `new_mask_o` repeats `cur_mask_i`.
- R6: `ack_valid_o` rises together with `take_o` only for level takes, and `ack_level_o` equals the level taken.
- R7: Taking a level does not clear it. The same level is taken again whenever the mask rises above it, with no new write from the controller.
- R8: `take_o` lasts one cycle. The cycle after a take makes no decision, so a request that stays acceptable is taken every other cycle.
- R9: A bus write changes an offset register only when `bus_size_i` is 1 (16 bits; 0 = 8 bits, 2 = 32 bits). The memory-control word, the mode word and all other offsets ignore writes.
- R10: Offset register n decodes at BASE_ADDR + 4n for n = 0..6, the memory-control word at BASE_ADDR + 0x20 and the mode word at BASE_ADDR + 0x40. A read returns its data with `bus_rvalid_o` one cycle after the request. Any other address reads as zero.
- R11: A taken reset request reports kind 1 and handler address RST_PC, and its pending flag clears. Kind 0 means no take.
- R12: A request pulse reaches the pending state on the clock edge that samples it, and a take appears on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| rst_req_i | input | 1 | Reset request pulse |
| nmi_req_i | input | 1 | Non-maskable interrupt pulse |
| lvl_we_i | input | 1 | Controller writes a new pending level |
| lvl_i | input | LVL_W | New pending level (all ones = none) |
| cur_mask_i | input | LVL_W | Current mask level of the core |
| bus_req_i | input | 1 | Register bus request |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_addr_i | input | ADDR_W | Absolute byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data |
| bus_rvalid_o | output | 1 | Read data valid |
| take_o | output | 1 | One-cycle take pulse to the core |
| take_kind_o | output | 2 | 0 none, 1 reset, 2 NMI, 3 level |
| take_pc_o | output | PC_W | Handler address |
| new_mask_o | output | LVL_W | Mask level for the status word |
| ack_valid_o | output | 1 | Level acknowledge pulse |
| ack_level_o | output | LVL_W | Level being acknowledged |

## Verification
The bench builds the block with BASE_ADDR set to 0x20000100. Correct decode then depends on subtracting the base, not on the low address bits alone. Addresses just below the base and between the windows are also reachable. It sets the memory-control and mode words to nonzero values, so a read of either can be told apart from the zero returned for an invalid address. LVL_W stays at 3, so all seven levels, the level-7 sentinel and every mask value are exercised.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  typedef enum logic [1:0] {
    TK_NONE  = 2'd0,
    TK_RESET = 2'd1,
    TK_NMI   = 2'd2,
    TK_LEVEL = 2'd3
  } take_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } bus_size_e;

  localparam int unsigned VEC_STRIDE = 4;

endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_req_i,
  input  logic             nmi_req_i,
  input  logic             lvl_we_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             clr_rst_i,
  input  logic             clr_nmi_i,
  output logic             rst_pend_o,
  output logic             nmi_pend_o,
  output logic [LVL_W-1:0] lvl_pend_o
);

  // A new pulse wins over a clear in the same cycle, so no request is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend_o <= 1'b0;
      nmi_pend_o <= 1'b0;
      lvl_pend_o <= '1;
    end else begin
      rst_pend_o <= rst_req_i | (rst_pend_o & ~clr_rst_i);
      nmi_pend_o <= nmi_req_i | (nmi_pend_o & ~clr_nmi_i);
      if (lvl_we_i) lvl_pend_o <= lvl_i;
    end
  end

endmodule

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
  import irq_accept_pkg::*;
#(
  parameter int unsigned LVL_W      = 3,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 32,
  parameter logic [31:0] BASE_ADDR  = 32'h2000_0000,
  parameter int unsigned MEMCTL_OFF = 32'h20,
  parameter int unsigned MODE_OFF   = 32'h40,
  parameter logic [15:0] MEMCTL_VAL = 16'h0000,
  parameter logic [15:0] MODE_VAL   = 16'h0000
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     bus_req_i,
  input  logic                                     bus_wr_i,
  input  logic [1:0]                               bus_size_i,
  input  logic [ADDR_W-1:0]                        bus_addr_i,
  input  logic [DATA_W-1:0]                        bus_wdata_i,
  output logic [DATA_W-1:0]                        bus_rdata_o,
  output logic                                     bus_rvalid_o,
  output logic [(1<<LVL_W)-2:0][DATA_W-1:0]        vec_o
);

  localparam int unsigned NUM_LVL = (1 << LVL_W) - 1;

  if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
    $error("irq_vec_regs: BASE_ADDR must be 4-byte aligned");
  end

  logic [ADDR_W-1:0]  offset;
  logic [NUM_LVL-1:0] hit_vec;
  logic               hit_memctl;
  logic               hit_mode;
  logic               wr_half;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  vec_q [NUM_LVL];

  assign offset     = bus_addr_i - ADDR_W'(BASE_ADDR);
  assign hit_memctl = (offset == ADDR_W'(MEMCTL_OFF));
  assign hit_mode   = (offset == ADDR_W'(MODE_OFF));
  assign wr_half    = bus_req_i && bus_wr_i && (bus_size_i == SZ_HALF);

  for (genvar n = 0; n < NUM_LVL; n++) begin : g_vec
    assign hit_vec[n] = (offset == ADDR_W'(n * VEC_STRIDE));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     vec_q[n] <= '0;
      else if (wr_half && hit_vec[n]) vec_q[n] <= bus_wdata_i;
    end

    assign vec_o[n] = vec_q[n];
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < NUM_LVL; n++) begin
      if (hit_vec[n]) rd_mux = vec_q[n];
    end
    if (hit_memctl) rd_mux = DATA_W'(MEMCTL_VAL);
    if (hit_mode)   rd_mux = DATA_W'(MODE_VAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata_o  <= '0;
      bus_rvalid_o <= 1'b0;
    end else begin
      bus_rvalid_o <= bus_req_i && !bus_wr_i;
      if (bus_req_i && !bus_wr_i) bus_rdata_o <= rd_mux;
    end
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_accept_pkg::*;
#(
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned PC_W     = 32,
  parameter logic [31:0] VEC_BASE = 32'h4000_0000,
  parameter logic [31:0] NMI_PC   = 32'h4000_0008,
  parameter logic [31:0] RST_PC   = 32'h4000_0000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rst_pend_i,
  input  logic                              nmi_pend_i,
  input  logic [LVL_W-1:0]                  lvl_pend_i,
  input  logic [LVL_W-1:0]                  cur_mask_i,
  input  logic [(1<<LVL_W)-2:0][DATA_W-1:0] vec_i,
  output logic                              clr_rst_o,
  output logic                              clr_nmi_o,
  output logic                              take_o,
  output logic [1:0]                        take_kind_o,
  output logic [PC_W-1:0]                   take_pc_o,
  output logic [LVL_W-1:0]                  new_mask_o,
  output logic                              ack_valid_o,
  output logic [LVL_W-1:0]                  ack_level_o
);

  localparam int unsigned NUM_LVL = (1 << LVL_W) - 1;

  take_kind_e        kind_d;
  logic [DATA_W-1:0] vec_sel;
  logic [PC_W-1:0]   pc_d;
  logic [LVL_W-1:0]  mask_d;

  always_comb begin
    vec_sel = '0;
    for (int n = 0; n < NUM_LVL; n++) begin
      if (lvl_pend_i == LVL_W'(n)) vec_sel = vec_i[n];
    end
  end

  // The cycle right after a take is a quiet cycle: the core is loading
  // its new mask, so no decision is made on a stale mask value.
  always_comb begin
    kind_d = TK_NONE;
    if (!take_o) begin
      if (rst_pend_i)                     kind_d = TK_RESET;
      else if (nmi_pend_i)                kind_d = TK_NMI;
      else if (lvl_pend_i < cur_mask_i)   kind_d = TK_LEVEL;
    end
  end

  always_comb begin
    unique case (kind_d)
      TK_RESET: pc_d = PC_W'(RST_PC);
      TK_NMI:   pc_d = PC_W'(NMI_PC);
      TK_LEVEL: pc_d = PC_W'(VEC_BASE) + PC_W'(vec_sel);
      default:  pc_d = '0;
    endcase
    mask_d = (kind_d == TK_LEVEL) ? lvl_pend_i : cur_mask_i;
  end

  assign clr_rst_o = (kind_d == TK_RESET);
  assign clr_nmi_o = (kind_d == TK_NMI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o      <= 1'b0;
      take_kind_o <= TK_NONE;
      take_pc_o   <= '0;
      new_mask_o  <= '0;
      ack_valid_o <= 1'b0;
      ack_level_o <= '0;
    end else begin
      take_o      <= (kind_d != TK_NONE);
      take_kind_o <= kind_d;
      take_pc_o   <= pc_d;
      new_mask_o  <= (kind_d != TK_NONE) ? mask_d : '0;
      ack_valid_o <= (kind_d == TK_LEVEL);
      ack_level_o <= (kind_d == TK_LEVEL) ? lvl_pend_i : '0;
    end
  end

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit #(
  parameter int unsigned LVL_W      = 3,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PC_W       = 32,
  parameter logic [31:0] BASE_ADDR  = 32'h2000_0000,
  parameter logic [31:0] VEC_BASE   = 32'h4000_0000,
  parameter logic [31:0] NMI_PC     = 32'h4000_0008,
  parameter logic [31:0] RST_PC     = 32'h4000_0000,
  parameter int unsigned MEMCTL_OFF = 32'h20,
  parameter int unsigned MODE_OFF   = 32'h40,
  parameter logic [15:0] MEMCTL_VAL = 16'h0000,
  parameter logic [15:0] MODE_VAL   = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req_i,
  input  logic              nmi_req_i,
  input  logic              lvl_we_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [LVL_W-1:0]  cur_mask_i,
  input  logic              bus_req_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_size_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              take_o,
  output logic [1:0]        take_kind_o,
  output logic [PC_W-1:0]   take_pc_o,
  output logic [LVL_W-1:0]  new_mask_o,
  output logic              ack_valid_o,
  output logic [LVL_W-1:0]  ack_level_o
);

  localparam int unsigned NUM_LVL = (1 << LVL_W) - 1;

  logic                            rst_pend;
  logic                            nmi_pend;
  logic [LVL_W-1:0]                lvl_pend;
  logic                            clr_rst;
  logic                            clr_nmi;
  logic [NUM_LVL-1:0][DATA_W-1:0]  vec;

  irq_pending #(.LVL_W(LVL_W)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_req_i  (rst_req_i),
    .nmi_req_i  (nmi_req_i),
    .lvl_we_i   (lvl_we_i),
    .lvl_i      (lvl_i),
    .clr_rst_i  (clr_rst),
    .clr_nmi_i  (clr_nmi),
    .rst_pend_o (rst_pend),
    .nmi_pend_o (nmi_pend),
    .lvl_pend_o (lvl_pend)
  );

  irq_vec_regs #(
    .LVL_W      (LVL_W),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .MEMCTL_OFF (MEMCTL_OFF),
    .MODE_OFF   (MODE_OFF),
    .MEMCTL_VAL (MEMCTL_VAL),
    .MODE_VAL   (MODE_VAL)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_i    (bus_req_i),
    .bus_wr_i     (bus_wr_i),
    .bus_size_i   (bus_size_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o),
    .vec_o        (vec)
  );

  irq_arbiter #(
    .LVL_W    (LVL_W),
    .DATA_W   (DATA_W),
    .PC_W     (PC_W),
    .VEC_BASE (VEC_BASE),
    .NMI_PC   (NMI_PC),
    .RST_PC   (RST_PC)
  ) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_pend_i  (rst_pend),
    .nmi_pend_i  (nmi_pend),
    .lvl_pend_i  (lvl_pend),
    .cur_mask_i  (cur_mask_i),
    .vec_i       (vec),
    .clr_rst_o   (clr_rst),
    .clr_nmi_o   (clr_nmi),
    .take_o      (take_o),
    .take_kind_o (take_kind_o),
    .take_pc_o   (take_pc_o),
    .new_mask_o  (new_mask_o),
    .ack_valid_o (ack_valid_o),
    .ack_level_o (ack_level_o)
  );

endmodule

// File: rtl/irq_accept_unit_chk.sv
module irq_accept_unit_chk #(
  parameter int unsigned LVL_W  = 3,
  parameter int unsigned PC_W   = 32,
  parameter logic [31:0] NMI_PC = 32'h4000_0008,
  parameter logic [31:0] RST_PC = 32'h4000_0000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] cur_mask_i,
  input logic             bus_req_i,
  input logic             bus_wr_i,
  input logic             bus_rvalid_o,
  input logic             take_o,
  input logic [1:0]       take_kind_o,
  input logic [PC_W-1:0]  take_pc_o,
  input logic [LVL_W-1:0] new_mask_o,
  input logic             ack_valid_o,
  input logic [LVL_W-1:0] ack_level_o
);

  a_r8_single_take: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);

  a_r6_ack_only_level: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> (take_o && take_kind_o == 2'd3));

  a_r5_mask_is_level: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_kind_o == 2'd3) |-> (new_mask_o == ack_level_o && ack_valid_o));

  a_r3_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_kind_o == 2'd3) |-> (ack_level_o < $past(cur_mask_i)));

  a_r4_nmi_target: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_kind_o == 2'd2) |-> (take_pc_o == PC_W'(NMI_PC)));

  a_r11_reset_target: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && take_kind_o == 2'd1) |-> (take_pc_o == PC_W'(RST_PC)));

  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_i && !bus_wr_i) |=> bus_rvalid_o);

  a_r11_kind_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (take_kind_o == 2'd0) |-> !take_o);

endmodule

bind irq_accept_unit irq_accept_unit_chk #(
  .LVL_W  (LVL_W),
  .PC_W   (PC_W),
  .NMI_PC (NMI_PC),
  .RST_PC (RST_PC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cur_mask_i   (cur_mask_i),
  .bus_req_i    (bus_req_i),
  .bus_wr_i     (bus_wr_i),
  .bus_rvalid_o (bus_rvalid_o),
  .take_o       (take_o),
  .take_kind_o  (take_kind_o),
  .take_pc_o    (take_pc_o),
  .new_mask_o   (new_mask_o),
  .ack_valid_o  (ack_valid_o),
  .ack_level_o  (ack_level_o)
);

// File: tb/irq_accept_unit_tb.sv
module irq_accept_unit_tb;

  localparam int unsigned LW    = 3;
  localparam logic [31:0] BASE  = 32'h2000_0100;
  localparam logic [31:0] VECB  = 32'h4000_0000;
  localparam logic [31:0] NMIPC = 32'h4000_0008;
  localparam logic [31:0] RSTPC = 32'h4000_0000;
  localparam logic [15:0] MCV   = 16'h00A5;
  localparam logic [15:0] MDV   = 16'h0300;
  localparam logic [1:0]  K_NONE = 2'd0, K_RST = 2'd1, K_NMI = 2'd2, K_LVL = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 0, nmi_req = 0, lvl_we = 0;
  logic [LW-1:0] lvl_in = '0, cur_mask = '0;
  logic bus_req = 0, bus_wr = 0;
  logic [1:0] bus_size = 2'd1;
  logic [31:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic bus_rvalid, take, ack_valid;
  logic [1:0] take_kind;
  logic [31:0] take_pc;
  logic [LW-1:0] new_mask, ack_level;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] vec_m [7];
  logic [LW-1:0] lvl_m = 3'd7;

  always #2 clk = ~clk;

  irq_accept_unit #(
    .BASE_ADDR(BASE), .MEMCTL_VAL(MCV), .MODE_VAL(MDV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req), .nmi_req_i(nmi_req),
    .lvl_we_i(lvl_we), .lvl_i(lvl_in), .cur_mask_i(cur_mask),
    .bus_req_i(bus_req), .bus_wr_i(bus_wr), .bus_size_i(bus_size),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvalid_o(bus_rvalid), .take_o(take), .take_kind_o(take_kind),
    .take_pc_o(take_pc), .new_mask_o(new_mask), .ack_valid_o(ack_valid),
    .ack_level_o(ack_level)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [31:0] addr);
    logic [31:0] off = addr - BASE;
    if (off <= 32'h18 && off[1:0] == 2'b00) return vec_m[off[4:2]];
    if (off == 32'h20) return MCV;
    if (off == 32'h40) return MDV;
    return 16'h0000;
  endfunction

  function automatic logic [31:0] pick_addr(input int unsigned k);
    case (k % 11)
      7:  return BASE + 32'h20;
      8:  return BASE + 32'h40;
      9:  return BASE + 32'h1C;
      10: return BASE - 32'h4;
      default: return BASE + 32'(4 * (k % 11));
    endcase
  endfunction

  task automatic bus_write(input logic [31:0] a, input logic [1:0] sz, input logic [15:0] d);
    logic [31:0] off = a - BASE;
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
    if (sz == 2'd1 && off <= 32'h18 && off[1:0] == 2'b00) vec_m[off[4:2]] = d;
  endtask

  task automatic bus_read(input logic [31:0] a, input string req);
    logic [15:0] e = exp_read(a);
    @(negedge clk);
    bus_req = 1; bus_wr = 0; bus_addr = a; bus_size = 2'd1;
    @(posedge clk); #1;
    chk(bus_rvalid == 1'b1, req, "rvalid", 32'(bus_rvalid), 32'd1);
    chk(bus_rdata == e, req, "rdata", 32'(bus_rdata), 32'(e));
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic check_take(input logic [1:0] k, input logic [LW-1:0] mk, input string req);
    logic [31:0] epc;
    logic [LW-1:0] em;
    case (k)
      K_RST: epc = RSTPC;
      K_NMI: epc = NMIPC;
      K_LVL: epc = VECB + 32'(vec_m[lvl_m]);
      default: epc = 32'h0;
    endcase
    em = (k == K_LVL) ? lvl_m : mk;
    chk(take == (k != K_NONE), req, "take", 32'(take), 32'(k != K_NONE));
    chk(take_kind == k, req, "kind", 32'(take_kind), 32'(k));
    if (k != K_NONE) begin
      chk(take_pc == epc, req, "pc", take_pc, epc);
      chk(new_mask == em, req, "new_mask", 32'(new_mask), 32'(em));
    end
    chk(ack_valid == (k == K_LVL), "R6", "ack_valid", 32'(ack_valid), 32'(k == K_LVL));
    if (k == K_LVL) chk(ack_level == lvl_m, "R6", "ack_level", 32'(ack_level), 32'(lvl_m));
  endtask

  // Pulses are sampled on the first edge (R12); the mask is applied after it,
  // so the decision edge that follows sees the new pending state and mask.
  task automatic irq_case(input bit r, input bit n, input bit lw, input logic [LW-1:0] lv,
                          input logic [LW-1:0] mk, input string req);
    logic [1:0] k;
    @(negedge clk);
    rst_req = r; nmi_req = n; lvl_we = lw; lvl_in = lv;
    @(negedge clk);
    rst_req = 0; nmi_req = 0; lvl_we = 0; cur_mask = mk;
    if (lw) lvl_m = lv;
    if (r) k = K_RST;
    else if (n) k = K_NMI;
    else if (lvl_m < mk) k = K_LVL;
    else k = K_NONE;
    @(posedge clk); #1;
    check_take(k, mk, req);
  endtask

  task automatic drain();
    @(negedge clk);
    cur_mask = '0;
    repeat (6) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 7; i++) vec_m[i] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    // R1: reset state
    chk(take == 0, "R1", "take after reset", 32'(take), 32'd0);
    bus_read(BASE + 32'h8, "R1");
    irq_case(0, 0, 0, 3'd0, 3'd7, "R1");   // pending level 7 -> nothing taken
    drain();

    // R10 / R9: decode and write sizes
    bus_read(BASE + 32'h20, "R10");
    bus_read(BASE + 32'h40, "R10");
    bus_read(BASE + 32'h24, "R10");
    bus_write(BASE + 32'h14, 2'd1, 16'h1234);
    bus_read(BASE + 32'h14, "R10");
    bus_write(BASE + 32'h8, 2'd0, 16'hBEEF);   // byte write ignored
    bus_read(BASE + 32'h8, "R9");
    bus_write(BASE + 32'h8, 2'd2, 16'hCAFE);   // word write ignored
    bus_read(BASE + 32'h8, "R9");
    bus_write(BASE + 32'h20, 2'd1, 16'h5555);  // read-only
    bus_read(BASE + 32'h20, "R9");
    bus_write(BASE + 32'h40, 2'd1, 16'h6666);
    bus_read(BASE + 32'h40, "R9");
    bus_write(BASE + 32'h18, 2'd1, 16'h0F00);
    bus_write(BASE + 32'h0, 2'd1, 16'h0040);

    // R5: level take target and mask
    irq_case(0, 0, 1, 3'd5, 3'd6, "R5");
    drain();
    // R3: equal level not taken, level 7 never
    irq_case(0, 0, 1, 3'd4, 3'd4, "R3");
    drain();
    irq_case(0, 0, 1, 3'd7, 3'd7, "R3");
    drain();
    // R7: level stays pending after being taken
    irq_case(0, 0, 1, 3'd6, 3'd7, "R7");
    drain();
    irq_case(0, 0, 0, 3'd0, 3'd7, "R7");
    drain();
    // R8: a standing request is taken every other cycle
    irq_case(0, 0, 1, 3'd0, 3'd7, "R8");
    @(posedge clk); #1;
    chk(take == 0, "R8", "quiet cycle", 32'(take), 32'd0);
    @(posedge clk); #1;
    check_take(K_LVL, 3'd7, "R8");
    drain();
    // R2 / R11 / R4: reset over NMI over level
    irq_case(0, 1, 1, 3'd1, 3'd7, "R2");
    drain();
    irq_case(1, 1, 1, 3'd7, 3'd7, "R11");
    @(posedge clk); #1;
    chk(take == 0, "R2", "quiet after reset", 32'(take), 32'd0);
    @(posedge clk); #1;
    check_take(K_NMI, 3'd7, "R2");
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(take == 0, "R4", "nmi cleared", 32'(take), 32'd0);
    drain();
    irq_case(0, 0, 0, 3'd0, 3'd7, "R4");        // level 7 pending, no NMI retake
    drain();

    // Random mix
    for (int it = 0; it < 80; it++) begin
      int unsigned op = $urandom % 3;
      if (op == 0) begin
        bus_write(pick_addr($urandom), 2'($urandom % 3), 16'($urandom));
      end else if (op == 1) begin
        bus_read(pick_addr($urandom), "R10");
      end else begin
        irq_case(($urandom % 8) == 0, ($urandom % 5) == 0, ($urandom % 2) == 0,
                 LW'($urandom), LW'($urandom), "R12");
        drain();
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule